// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers seven interrupt sources for a small signal-processing core and tells the program sequencer where to branch. The sources are the chip reset, a dedicated external pin, transmit and receive requests from two serial ports, and an interval timer. The receive and transmit requests of the second serial port can be swapped for two more external pins. Each source has a fixed branch target. The targets are spaced four instruction words apart, so a short handler fits inside its own slot.

Software controls the block through one write port. That port writes three registers: a mask register with one enable bit per maskable source, a control register, and a write-only force/clear register. The control register sets each external pin as edge- or level-sensitive and picks nested or one-at-a-time servicing. When the sequencer accepts a request, the block saves the arithmetic status word, the mode status word and the current mask on a seven-entry status stack. A return from interrupt pops that entry, restores the mask and hands the two status words back to the sequencer. The sequencer can also push and pop the stack directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, `irq_take` is 1 and `irq_vec` is 0x0000. After reset, every maskable source is disabled, all external pins are level-sensitive, servicing is sequential and the status stack is empty, so a pop returns no entry.
- R2: The maskable sources are numbered 1 to 6 in falling priority: 1 = pin `ext_irq_n[2]`; 2 = `sport_req[0]`; 3 = `sport_req[1]`; 4 = `sport_req[2]` or pin `ext_irq_n[1]`; 5 = `sport_req[3]` or pin `ext_irq_n[0]`; 6 = `timer_req`. The granted source n is presented as `irq_vec` = 4·n. When nothing is granted, `irq_take` is 0 and `irq_vec` is 0.
- R3: A pending source competes only if its enable bit is 1. The enable bit for source n is bit n-1 of a write with `wr_sel`=0. The lowest-numbered enabled pending source wins.
- R4: A pin set to edge-sensitive latches a request on a high-to-low transition. The request stays pending after the pin returns high and is cleared when it is acknowledged. A new falling edge in the acknowledge cycle leaves it pending. Edge selection comes from a write with `wr_sel`=1: bit 0 for `ext_irq_n[0]`, bit 1 for `ext_irq_n[1]`, bit 2 for `ext_irq_n[2]`, where 1 means edge.
- R5: A level-sensitive pin requests exactly while it is low, in the same cycle, and leaves nothing latched.
- R6: A write with `wr_sel`=2 sets the request of source n when bit n-1 is 1 and clears it when bit n+5 is 1. Clear wins when both bits are 1.
- R7: With bit 4 of the control register at 0, no request is granted while a service is active. A service becomes active on acknowledge and ends on return.
- R8: With bit 4 of the control register at 1, a request is granted only if its priority is strictly higher than every active service. A return ends the highest-priority active service.
- R9: An acknowledge (`irq_take`&`irq_ack`) or `sts_push` pushes {`astat_in`, `mstat_in`, mask}. A return (`irq_rti`) or `sts_pop` on a non-empty stack pops in last-in, first-out order: the mask is restored at that edge, and `restore_vld` pulses for one cycle with the saved words on `astat_rst`/`mstat_rst`. When a push and a pop fall in the same cycle, the push is taken and the pop is ignored.
- R10: A push that meets a full stack of 7 entries leaves the stack unchanged and sets `stk_ovf`, which holds until reset.
- R11: With `ser1_as_irq`=1, sources 4 and 5 come from pins `ext_irq_n[1]` and `ext_irq_n[0]` and the serial requests are ignored. With `ser1_as_irq`=0, those pins are ignored.
- R12: A one-cycle pulse on an internal request (serial or timer) stays pending until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the highest-priority source |
| ext_irq_n | input | 3 | Active-low external request pins |
| ser1_as_irq | input | 1 | Routes sources 4 and 5 from pins instead of serial port 1 |
| sport_req | input | 4 | Serial requests: [0] port0 tx, [1] port0 rx, [2] port1 tx, [3] port1 rx |
| timer_req | input | 1 | Timer request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mask, 1 control, 2 force/clear |
| wr_data | input | 12 | Register write data |
| irq_ack | input | 1 | Sequencer accepts the presented vector |
| irq_rti | input | 1 | Return from interrupt |
| sts_push | input | 1 | Direct push of the status stack |
| sts_pop | input | 1 | Direct pop of the status stack |
| astat_in | input | 8 | Arithmetic status word to save |
| mstat_in | input | 7 | Mode status word to save |
| irq_take | output | 1 | A vector is presented |
| irq_vec | output | 14 | Branch target of the granted source |
| restore_vld | output | 1 | Saved status words are valid |
| astat_rst | output | 8 | Restored arithmetic status |
| mstat_rst | output | 7 | Restored mode status |
| stk_ovf | output | 1 | Sticky stack-overflow flag |

## Verification
Two functions can collide on one clock edge: the acknowledge that clears an edge-latched pin request, and a fresh falling edge on that same pin. The bench first latches the request and then raises the pin again. In the acknowledge cycle it drives the pin low. It then returns from the service and expects the vector of that pin to be offered again. A second collision joins a mask write with a later pop: the bench writes a zero mask while a service is open and judges the return by whether the saved mask lets a pending source through.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC    = 7;          // reset plus six maskable sources
    localparam int NMSK    = NSRC - 1;
    localparam int EXT_N   = 3;          // external request pins
    localparam int SPT_N   = 4;          // serial request lines
    localparam int WD_W    = 2 * NMSK;   // force bits then clear bits
    localparam int NEST_BIT = 4;
    localparam int SLOT_LG = 2;          // four words per vector slot

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FRC  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic             nest;
        logic [EXT_N-1:0] edge_sel;
    } ctrl_t;

    function automatic int unsigned slot_base(input int unsigned src);
        return src << SLOT_LG;
    endfunction

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic edge_mode,
    input  logic pin_n,
    input  logic int_pulse,
    input  logic frc,
    input  logic clr,
    input  logic ack,
    output logic req
);

    logic pin_q;
    logic latch_q;
    logic fall;
    logic set_now;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= pin_n;
    end

    always_comb begin
        fall    = ext_mode & edge_mode & pin_q & ~pin_n;
        set_now = fall | (~ext_mode & int_pulse) | frc;
    end

    always_ff @(posedge clk) begin
        if (rst)          latch_q <= 1'b0;
        else if (clr)     latch_q <= 1'b0;
        else if (set_now) latch_q <= 1'b1;
        else if (ack)     latch_q <= 1'b0;
    end

    assign req = latch_q | (ext_mode & ~edge_mode & ~pin_n);

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && edge_mode && $fell(pin_n) && !clr) |=> req); // R4

    AST_INT_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && int_pulse && !clr) |=> req); // R12

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NM = irqc_pkg::NMSK,
    parameter int VW = 14
) (
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] mask,
    input  logic [NM-1:0] active,
    input  logic          nest,
    output logic          take,
    output logic [VW-1:0] vec,
    output logic [NM-1:0] grant_oh
);
    localparam int IW = $clog2(NM + 1);

    logic [NM-1:0] cand;
    logic [IW-1:0] sel_ix;
    logic [IW-1:0] act_ix;
    logic          allow;

    always_comb begin
        cand   = req & mask;
        sel_ix = '0;
        act_ix = IW'(NM);
        for (int i = NM - 1; i >= 0; i--) begin
            if (cand[i])   sel_ix = IW'(i);
            if (active[i]) act_ix = IW'(i);
        end
        allow    = (active == '0) || (nest && (sel_ix < act_ix));
        take     = 1'b0;
        vec      = '0;
        grant_oh = '0;
        if (rst) begin
            take = 1'b1;
        end else if ((cand != '0) && allow) begin
            take             = 1'b1;
            grant_oh[sel_ix] = 1'b1;
            vec              = VW'(irqc_pkg::slot_base(32'(sel_ix) + 32'd1));
        end
    end

endmodule

// File: rtl/irqc_stat_stack.sv
module irqc_stat_stack #(
    parameter int DW    = 21,
    parameter int DEPTH = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] top_ent,
    output logic          empty,
    output logic [DW-1:0] dout,
    output logic          restore_vld,
    output logic          ovf
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] depth;
    logic [PW-1:0] top_ix;
    logic          full;
    logic          do_pop;

    always_comb begin
        full    = (depth == PW'(DEPTH));
        empty   = (depth == '0);
        top_ix  = depth - PW'(1);
        top_ent = mem[top_ix[IW-1:0]];
        do_pop  = pop && !push && !empty;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[depth[IW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth       <= '0;
            dout        <= '0;
            restore_vld <= 1'b0;
            ovf         <= 1'b0;
        end else begin
            restore_vld <= 1'b0;
            if (push) begin
                if (full) ovf   <= 1'b1;
                else      depth <= depth + PW'(1);
            end else if (do_pop) begin
                depth       <= top_ix;
                dout        <= top_ent;
                restore_vld <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (full && ovf)); // R10

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (depth == $past(depth) + PW'(1))); // R9

    AST_POP_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> restore_vld); // R9

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int ASTAT_W   = 8,
    parameter int MSTAT_W   = 7,
    parameter int STK_DEPTH = 7,
    parameter int VEC_W     = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [irqc_pkg::EXT_N-1:0] ext_irq_n,
    input  logic                       ser1_as_irq,
    input  logic [irqc_pkg::SPT_N-1:0] sport_req,
    input  logic                       timer_req,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [irqc_pkg::WD_W-1:0]  wr_data,
    input  logic                       irq_ack,
    input  logic                       irq_rti,
    input  logic                       sts_push,
    input  logic                       sts_pop,
    input  logic [ASTAT_W-1:0]         astat_in,
    input  logic [MSTAT_W-1:0]         mstat_in,
    output logic                       irq_take,
    output logic [VEC_W-1:0]           irq_vec,
    output logic                       restore_vld,
    output logic [ASTAT_W-1:0]         astat_rst,
    output logic [MSTAT_W-1:0]         mstat_rst,
    output logic                       stk_ovf
);
    import irqc_pkg::*;

    localparam int ENT_W = ASTAT_W + MSTAT_W + NMSK;

    wsel_e             sel;
    ctrl_t             ctrl_q;
    logic [NMSK-1:0]   mask_q;
    logic [NMSK-1:0]   active_q;
    logic [NMSK-1:0]   act_low;
    logic [NMSK-1:0]   frc_v, clr_v;
    logic [NMSK-1:0]   s_ext, s_edge, s_pin, s_int;
    logic [NMSK-1:0]   req_v;
    logic [NMSK-1:0]   grant_oh;
    logic              ack_go, push_go, pop_go, rti_go;
    logic [ENT_W-1:0]  push_ent, top_ent, pop_ent;
    logic              stk_empty;

    always_comb begin
        sel   = wsel_e'(wr_sel);
        frc_v = (wr_en && sel == SEL_FRC) ? wr_data[NMSK-1:0]      : '0;
        clr_v = (wr_en && sel == SEL_FRC) ? wr_data[2*NMSK-1:NMSK] : '0;
        // source routing: index g serves source g+1
        s_ext  = {1'b0, ser1_as_irq, ser1_as_irq, 1'b0, 1'b0, 1'b1};
        s_edge = {1'b0, ctrl_q.edge_sel[0], ctrl_q.edge_sel[1], 1'b0, 1'b0, ctrl_q.edge_sel[2]};
        s_pin  = {1'b1, ext_irq_n[0], ext_irq_n[1], 1'b1, 1'b1, ext_irq_n[2]};
        s_int  = {timer_req, sport_req[3], sport_req[2], sport_req[1], sport_req[0], 1'b0};
    end

    for (genvar g = 0; g < NMSK; g++) begin : g_src
        irqc_src_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .ext_mode  (s_ext[g]),
            .edge_mode (s_edge[g]),
            .pin_n     (s_pin[g]),
            .int_pulse (s_int[g]),
            .frc       (frc_v[g]),
            .clr       (clr_v[g]),
            .ack       (grant_oh[g] & ack_go),
            .req       (req_v[g])
        );
    end

    irqc_arbiter #(.NM(NMSK), .VW(VEC_W)) u_arb (
        .rst      (rst),
        .req      (req_v),
        .mask     (mask_q),
        .active   (active_q),
        .nest     (ctrl_q.nest),
        .take     (irq_take),
        .vec      (irq_vec),
        .grant_oh (grant_oh)
    );

    always_comb begin
        ack_go   = irq_take && irq_ack && !rst;
        push_go  = ack_go || sts_push;
        pop_go   = (irq_rti || sts_pop) && !push_go;
        rti_go   = irq_rti && !push_go;
        act_low  = active_q & (~active_q + NMSK'(1));
        push_ent = {astat_in, mstat_in, mask_q};
    end

    irqc_stat_stack #(.DW(ENT_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk         (clk),
        .rst         (rst),
        .push        (push_go),
        .pop         (pop_go),
        .din         (push_ent),
        .top_ent     (top_ent),
        .empty       (stk_empty),
        .dout        (pop_ent),
        .restore_vld (restore_vld),
        .ovf         (stk_ovf)
    );

    assign astat_rst = pop_ent[ENT_W-1 -: ASTAT_W];
    assign mstat_rst = pop_ent[NMSK +: MSTAT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            ctrl_q   <= '0;
            active_q <= '0;
        end else begin
            if (pop_go && !stk_empty)
                mask_q <= top_ent[NMSK-1:0];
            else if (wr_en && sel == SEL_MASK)
                mask_q <= wr_data[NMSK-1:0];
            if (wr_en && sel == SEL_CTRL) begin
                ctrl_q.edge_sel <= wr_data[EXT_N-1:0];
                ctrl_q.nest     <= wr_data[NEST_BIT];
            end
            if (ack_go)      active_q <= active_q | grant_oh;
            else if (rti_go) active_q <= active_q & ~act_low;
        end
    end

    AST_SEQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ack_go && !ctrl_q.nest) |-> (active_q == '0)); // R7

    AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (rst)
        ack_go |-> ((active_q & ((grant_oh << 1) - NMSK'(1))) == '0)); // R8

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ext_irq_n = 3'b111;
    logic        ser1_as_irq = 1'b0;
    logic [3:0]  sport_req = '0;
    logic        timer_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic        irq_rti = 1'b0;
    logic        sts_push = 1'b0;
    logic        sts_pop = 1'b0;
    logic [7:0]  astat_in = '0;
    logic [6:0]  mstat_in = '0;
    logic        irq_take;
    logic [13:0] irq_vec;
    logic        restore_vld;
    logic [7:0]  astat_rst;
    logic [6:0]  mstat_rst;
    logic        stk_ovf;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .ser1_as_irq(ser1_as_irq),
        .sport_req(sport_req), .timer_req(timer_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack), .irq_rti(irq_rti),
        .sts_push(sts_push), .sts_pop(sts_pop), .astat_in(astat_in),
        .mstat_in(mstat_in), .irq_take(irq_take), .irq_vec(irq_vec),
        .restore_vld(restore_vld), .astat_rst(astat_rst), .mstat_rst(mstat_rst),
        .stk_ovf(stk_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [11:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic rti();
        irq_rti = 1'b1; tick(); irq_rti = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(); tick(); tick(); #1;
        chk("R1 take in reset", 32'(irq_take), 1);
        chk("R1 vec in reset", 32'(irq_vec), 0);
        tick(); rst = 1'b0; tick();
        wr(2, 12'h03F); #1;
        chk("R1 all masked after reset", 32'(irq_take), 0);
        sts_pop = 1'b1; tick(); sts_pop = 1'b0; #1;
        chk("R1 stack empty after reset", 32'(restore_vld), 0);

        // exhaustive mask sweep with all six sources pending
        for (int m = 0; m < 64; m++) begin
            int k;
            k = 0;
            for (int b = 5; b >= 0; b--) if (m[b]) k = b + 1;
            wr(0, 12'(m)); #1;
            chk("R3 take for mask", 32'(irq_take), (k != 0) ? 1 : 0);
            chk("R2 vector for mask", 32'(irq_vec), 32'(4 * k));
        end

        // sequential service and status save
        astat_in = 8'hC3; mstat_in = 7'h2A;
        ack(); #1;
        chk("R7 no grant while active", 32'(irq_take), 0);
        rti(); #1;
        chk("R9 restore pulse", 32'(restore_vld), 1);
        chk("R9 astat restored", 32'(astat_rst), 32'hC3);
        chk("R9 mstat restored", 32'(mstat_rst), 32'h2A);
        chk("R7 next source after return", 32'(irq_vec), 32'h8);

        // nested servicing
        wr(1, 12'h010); wr(2, 12'hFC0); wr(2, 12'h008); #1;
        chk("R8 first grant", 32'(irq_vec), 32'h10);
        ack(); wr(2, 12'h020); #1;
        chk("R8 lower priority blocked", 32'(irq_take), 0);
        wr(2, 12'h002); #1;
        chk("R8 higher priority preempts", 32'(irq_vec), 32'h8);
        ack(); rti(); #1;
        chk("R8 still blocked by outer service", 32'(irq_take), 0);
        rti(); #1;
        chk("R8 granted after both returns", 32'(irq_vec), 32'h18);
        wr(2, 12'hFC0); wr(1, 12'h000);

        // mask saved and restored across a service
        wr(2, 12'h004); astat_in = 8'hA5; mstat_in = 7'h5A;
        ack(); wr(0, 12'h000); wr(2, 12'h010); #1;
        chk("R3 zero mask blocks", 32'(irq_take), 0);
        rti(); #1;
        chk("R9 mask restored", 32'(irq_vec), 32'h14);
        chk("R9 astat of second save", 32'(astat_rst), 32'hA5);
        wr(2, 12'hFC0);

        // force and clear
        wr(2, 12'h082); #1;
        chk("R6 clear wins over force", 32'(irq_take), 0);
        wr(2, 12'h002); #1;
        chk("R6 force sets", 32'(irq_vec), 32'h8);
        wr(2, 12'h080); #1;
        chk("R6 clear removes", 32'(irq_take), 0);

        // edge-sensitive pin
        wr(1, 12'h004);
        ext_irq_n[2] = 1'b0; tick(); #1;
        chk("R4 falling edge latched", 32'(irq_vec), 32'h4);
        ext_irq_n[2] = 1'b1; tick(); #1;
        chk("R4 held after pin rises", 32'(irq_vec), 32'h4);
        ack(); rti(); #1;
        chk("R4 acknowledge clears", 32'(irq_take), 0);
        ext_irq_n[2] = 1'b0; tick();
        ext_irq_n[2] = 1'b1; tick();
        ext_irq_n[2] = 1'b0; irq_ack = 1'b1; tick();
        irq_ack = 1'b0; ext_irq_n[2] = 1'b1;
        rti(); #1;
        chk("R4 edge in ack cycle kept", 32'(irq_vec), 32'h4);
        ack(); rti(); #1;
        chk("R4 cleared again", 32'(irq_take), 0);

        // level-sensitive pin
        wr(1, 12'h000);
        ext_irq_n[2] = 1'b0; #1;
        chk("R5 level low requests", 32'(irq_vec), 32'h4);
        tick(); ext_irq_n[2] = 1'b1; #1;
        chk("R5 nothing latched", 32'(irq_take), 0);

        // serial port 1 versus pins
        wr(0, 12'h010);
        sport_req[3] = 1'b1; tick(); sport_req[3] = 1'b0; #1;
        chk("R12 serial pulse latched", 32'(irq_vec), 32'h14);
        tick(); tick(); #1;
        chk("R12 serial pulse still pending", 32'(irq_vec), 32'h14);
        wr(2, 12'hFC0);
        ext_irq_n[0] = 1'b0; tick(); #1;
        chk("R11 pin ignored in serial mode", 32'(irq_take), 0);
        ext_irq_n[0] = 1'b1; ser1_as_irq = 1'b1;
        sport_req[3] = 1'b1; tick(); sport_req[3] = 1'b0; #1;
        chk("R11 serial ignored in pin mode", 32'(irq_take), 0);
        ext_irq_n[0] = 1'b0; #1;
        chk("R11 pin 0 drives source 5", 32'(irq_vec), 32'h14);
        tick(); ext_irq_n[0] = 1'b1;
        wr(0, 12'h008); ext_irq_n[1] = 1'b0; #1;
        chk("R11 pin 1 drives source 4", 32'(irq_vec), 32'h10);
        tick(); ext_irq_n[1] = 1'b1; ser1_as_irq = 1'b0;

        // timer pulse
        wr(0, 12'h020);
        timer_req = 1'b1; tick(); timer_req = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #1; chk("R12 timer pending", 32'(irq_vec), 32'h18);
            tick();
        end
        ack(); rti(); #1;
        chk("R12 timer cleared by ack", 32'(irq_take), 0);

        // service every source in priority order
        wr(0, 12'h03F); wr(2, 12'h03F);
        for (int k = 1; k <= 6; k++) begin
            #1; chk("R2 ordered service", 32'(irq_vec), 32'(4 * k));
            ack(); rti();
        end
        #1; chk("R2 all served", 32'(irq_take), 0);

        // stack fill, overflow and drain
        for (int i = 1; i <= 7; i++) begin
            astat_in = 8'(i); sts_push = 1'b1; tick(); sts_push = 1'b0;
        end
        #1; chk("R10 no overflow at seven", 32'(stk_ovf), 0);
        astat_in = 8'hEE; sts_push = 1'b1; tick(); sts_push = 1'b0; #1;
        chk("R10 overflow flagged", 32'(stk_ovf), 1);
        for (int i = 7; i >= 1; i--) begin
            sts_pop = 1'b1; tick(); sts_pop = 1'b0; #1;
            chk("R9 pop valid", 32'(restore_vld), 1);
            chk("R10 pop order unchanged", 32'(astat_rst), 32'(i));
        end
        sts_pop = 1'b1; tick(); sts_pop = 1'b0; #1;
        chk("R10 stack held seven only", 32'(restore_vld), 0);
        chk("R10 overflow sticky", 32'(stk_ovf), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule